// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Round Engine

This block encrypts or decrypts one 64-bit block with the standard sixteen-round Feistel cipher, doing one round per clock. An accepted block first goes through the fixed initial bit permutation and is split into a 32-bit left half and a 32-bit right half. Each round widens the right half to 48 bits, adds the round subkey modulo 2, and passes the sum through eight 6-in/4-out substitution tables. The 32 table outputs go through the fixed 32-bit permutation and are then added into the left half. After the sixteenth round the halves go through the inverse permutation. No half-swap follows the last round.

The engine holds no key material. It drives a round index, and in the same cycle an external key schedule returns the 48-bit subkey for that round on `subkey_i`. Encryption and decryption use the same datapath. They differ only in the order in which the schedule hands out subkeys.

The input side uses a valid/ready handshake. `in_ready` is high exactly while the engine is idle. A block is taken on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_valid` has no effect, and the source may hold or withdraw its block. The output side has no back-pressure. The result stays on `out_block` until the next block completes, and a one-cycle `done` marks each new result.

Top module: `fcipher_core`

## Requirements
- R1: After reset, `busy` and `done` are 0, `in_ready` is 1, `round_idx` is 0 and `out_block` is all zeros.
- R2: `in_ready` equals the inverse of `busy`. A block is accepted only on a rising edge where `in_valid` and `in_ready` are both 1, and `busy` is 1 in the cycle after acceptance.
- R3: In the cycle after acceptance, `round_idx` is 0. It then rises by one per cycle up to 15. The subkey present on `subkey_i` in the cycle where `round_idx` equals n is used for round n, with n counted from 0.
- R4: `done` is 1 for exactly one cycle, 16 clock edges after the accepting edge. In that same cycle `busy` is 0 and `out_block` holds the result.
- R5: With the standard tables (the row index comes from the outer two bits of each 6-bit group and the column index from the inner four bits), plaintext 0x0123456789ABCDEF with the sixteen subkeys of key 0x133457799BBCDFF1 gives 0x85E813540F0AB405. Bit 63 is the first bit of the standard.
- R6: Supplying the same sixteen subkeys in reverse order (round n receives key 15−n) turns the output of an encryption back into its plaintext, for any block and any subkeys.
- R7: An `in_valid` pulse or held `in_valid` while `busy` is 1 is ignored. The block in flight keeps its round sequence and its result, and no extra `done` follows.
- R8: `out_block` changes only at the edge that raises `done`. It keeps its value through idle cycles and through the rounds of the next block.
- R9: The final stage feeds the new right half followed by the new left half into the inverse permutation, so no swap follows round 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers a block on `in_block` |
| in_ready | output | 1 | Engine is idle and will accept a block |
| in_block | input | 64 | Block to process, bit 63 first |
| subkey_i | input | 48 | Subkey for the round named by `round_idx` |
| round_idx | output | 4 | Index of the round the engine is computing |
| busy | output | 1 | A block is in flight |
| done | output | 1 | One-cycle pulse when a new result is on `out_block` |
| out_block | output | 64 | Last completed result, held until the next one |

## Verification
Two events can fall in the same cycle: the `done` pulse of one block, and `in_ready` returning high so that a waiting block is taken at the next edge. The bench holds `in_valid` high with a second block for the whole run of the first block. It then checks that the first result is correct and that `in_ready` is high in the done cycle. After that it checks that the second block starts with `round_idx` at 0, and that its own result arrives 16 edges later without disturbing the first result in the meantime. The second block is decrypted with reversed subkeys, so its expected value is the known plaintext.

// File: rtl/fcipher_pkg.sv
package fcipher_pkg;

  localparam int BLK_W  = 64;
  localparam int HALF_W = 32;
  localparam int EXP_W  = 48;
  localparam int N_SBOX = 8;

  // Source bit (1-based, 1 = MSB) for each output bit of the initial permutation.
  localparam logic [6:0] IP_SRC [64] = '{
    7'd58, 7'd50, 7'd42, 7'd34, 7'd26, 7'd18, 7'd10, 7'd2,
    7'd60, 7'd52, 7'd44, 7'd36, 7'd28, 7'd20, 7'd12, 7'd4,
    7'd62, 7'd54, 7'd46, 7'd38, 7'd30, 7'd22, 7'd14, 7'd6,
    7'd64, 7'd56, 7'd48, 7'd40, 7'd32, 7'd24, 7'd16, 7'd8,
    7'd57, 7'd49, 7'd41, 7'd33, 7'd25, 7'd17, 7'd9,  7'd1,
    7'd59, 7'd51, 7'd43, 7'd35, 7'd27, 7'd19, 7'd11, 7'd3,
    7'd61, 7'd53, 7'd45, 7'd37, 7'd29, 7'd21, 7'd13, 7'd5,
    7'd63, 7'd55, 7'd47, 7'd39, 7'd31, 7'd23, 7'd15, 7'd7
  };

  // Source bit (1-based) for each output bit of the 32-bit round permutation.
  localparam logic [5:0] PB_SRC [32] = '{
    6'd16, 6'd7,  6'd20, 6'd21, 6'd29, 6'd12, 6'd28, 6'd17,
    6'd1,  6'd15, 6'd23, 6'd26, 6'd5,  6'd18, 6'd31, 6'd10,
    6'd2,  6'd8,  6'd24, 6'd14, 6'd32, 6'd27, 6'd3,  6'd9,
    6'd19, 6'd13, 6'd30, 6'd6,  6'd22, 6'd11, 6'd4,  6'd25
  };

  // Substitution tables, entry (row*16 + col) in nibble order from the MSB.
  localparam logic [255:0] SBOX_ROM [N_SBOX] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
  };

  function automatic logic [BLK_W-1:0] init_perm(input logic [BLK_W-1:0] d);
    logic [BLK_W-1:0] r;
    r = '0;
    for (int i = 0; i < BLK_W; i++) begin
      r[6'(63 - i)] = d[6'(64 - int'(IP_SRC[i]))];
    end
    return r;
  endfunction

  // Inverse of the initial permutation, derived from the same table.
  function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] d);
    logic [BLK_W-1:0] r;
    r = '0;
    for (int i = 0; i < BLK_W; i++) begin
      r[6'(64 - int'(IP_SRC[i]))] = d[6'(63 - i)];
    end
    return r;
  endfunction

  // 32 -> 48 widening: group g takes source bits 4g .. 4g+5 (1-based, wrapping).
  function automatic logic [EXP_W-1:0] widen(input logic [HALF_W-1:0] d);
    logic [EXP_W-1:0] r;
    int src;
    r = '0;
    for (int g = 0; g < N_SBOX; g++) begin
      for (int j = 0; j < 6; j++) begin
        src = ((4 * g + j + 31) % 32) + 1;
        r[6'(47 - (6 * g + j))] = d[5'(32 - src)];
      end
    end
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] round_perm(input logic [HALF_W-1:0] d);
    logic [HALF_W-1:0] r;
    r = '0;
    for (int i = 0; i < HALF_W; i++) begin
      r[5'(31 - i)] = d[5'(32 - int'(PB_SRC[i]))];
    end
    return r;
  endfunction

endpackage

// File: rtl/fcipher_sbox.sv
module fcipher_sbox
  import fcipher_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic [5:0] six_i,
  output logic [3:0] nib_o
);

  localparam logic [255:0] ROM = SBOX_ROM[IDX];

  logic [5:0]   entry;
  logic [255:0] shifted;

  // Row from the outer bits, column from the inner four.
  assign entry   = {six_i[5], six_i[0], six_i[4:1]};
  assign shifted = ROM << (4 * entry);
  assign nib_o   = shifted[255:252];

endmodule

// File: rtl/fcipher_ffunc.sv
module fcipher_ffunc
  import fcipher_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  input  logic [EXP_W-1:0]  key_i,
  output logic [HALF_W-1:0] f_o
);

  logic [EXP_W-1:0]  mixed;
  logic [HALF_W-1:0] subst;

  assign mixed = widen(half_i) ^ key_i;

  for (genvar g = 0; g < N_SBOX; g++) begin : g_sbox
    fcipher_sbox #(.IDX(g)) u_sbox (
      .six_i (mixed[EXP_W-1-6*g -: 6]),
      .nib_o (subst[HALF_W-1-4*g -: 4])
    );
  end

  assign f_o = round_perm(subst);

endmodule

// File: rtl/fcipher_ctrl.sv
module fcipher_ctrl #(
  parameter int ROUNDS = 16,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             accept_o,
  output logic             step_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = in_valid && !busy_q;
  assign step_o   = busy_q;
  assign finish_o = busy_q && (cnt_q == LAST);
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= finish_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy_q) |=> (busy_q && cnt_q == '0)) else $error("accept"); // R2

  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)) else $error("step"); // R3

  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> (done_q && !busy_q)) else $error("finish"); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done width"); // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_valid && cnt_q != LAST) |=> (cnt_q != '0)) else $error("restart"); // R7

endmodule

// File: rtl/fcipher_core.sv
module fcipher_core
  import fcipher_pkg::*;
#(
  parameter int ROUNDS = 16,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_block,
  input  logic [47:0]      subkey_i,
  output logic [CNT_W-1:0] round_idx,
  output logic             busy,
  output logic             done,
  output logic [63:0]      out_block
);

  logic              accept, step, finish;
  logic [HALF_W-1:0] l_q, r_q, f_val, r_next;
  logic [BLK_W-1:0]  out_q;

  fcipher_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .accept_o (accept),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy),
    .done_o   (done),
    .cnt_o    (round_idx)
  );

  fcipher_ffunc u_ffunc (
    .half_i (r_q),
    .key_i  (subkey_i),
    .f_o    (f_val)
  );

  assign r_next = l_q ^ f_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q   <= '0;
      r_q   <= '0;
      out_q <= '0;
    end else if (accept) begin
      {l_q, r_q} <= init_perm(in_block);
    end else if (step) begin
      l_q <= r_q;
      r_q <= r_next;
      if (finish) begin
        // Halves enter the inverse permutation right-first: no closing swap.
        out_q <= final_perm({r_next, r_q});
      end
    end
  end

  assign in_ready  = !busy;
  assign out_block = out_q;

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready) else $error("ready at done"); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(out_block)) else $error("out moved"); // R8

  AST_OUT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_block) |-> done) else $error("out change"); // R8

endmodule

// File: tb/fcipher_core_test.sv
`timescale 1ns/1ps
module fcipher_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_block = '0;
  logic [47:0] subkey_i;
  logic [3:0]  round_idx;
  logic        busy, done;
  logic [63:0] out_block;

  logic [47:0] ks [16];
  logic        dec_mode = 1'b0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          ended = 1'b0;

  localparam logic [63:0] KAT_PT = 64'h0123456789ABCDEF;
  localparam logic [63:0] KAT_CT = 64'h85E813540F0AB405;

  always #10 clk = ~clk;

  fcipher_core uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .subkey_i(subkey_i), .round_idx(round_idx),
    .busy(busy), .done(done), .out_block(out_block)
  );

  // External key schedule stand-in: forward order encrypts, reversed decrypts.
  always_comb subkey_i = dec_mode ? ks[~round_idx] : ks[round_idx];

  function automatic logic [3:0] expect_idx(input int k);
    return 4'(k);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_kat_keys();
    ks = '{48'h1B02EFFC7072, 48'h79AED9DBC9E5, 48'h55FC8A42CF99, 48'h72ADD6DB351D,
           48'h7CEC07EB53A8, 48'h63A53E507B2F, 48'hEC84B7F618BC, 48'hF78A3AC13BFB,
           48'hE0DBEBEDE781, 48'hB1F347BA464F, 48'h215FD3DED386, 48'h7571F59467E9,
           48'h97C5D1FAEA41, 48'h5F43B7F2E73A, 48'hBF918D3D3F0A, 48'hCB3D8B0E17F5};
  endtask

  // Runs one block; noisy asserts in_valid mid-flight (R7).
  task automatic run_block(input logic [63:0] blk, input bit noisy, output logic [63:0] res);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready before start", 64'(in_ready), 64'd1);
    in_valid = 1'b1;
    in_block = blk;
    @(negedge clk);
    in_valid = 1'b0;
    check(busy && !in_ready && round_idx == 4'd0, "R2/R3 start", 64'(round_idx), 64'd0);
    for (int k = 1; k <= 16; k++) begin
      if (noisy && k == 3) begin
        in_valid = 1'b1;
        in_block = ~blk;
      end
      if (noisy && k == 7) in_valid = 1'b0;
      @(negedge clk);
      if (k < 16) begin
        check(!done && busy, "R4 no early done", 64'(done), 64'd0);
        check(round_idx == expect_idx(k), "R3 round index", 64'(round_idx), 64'(expect_idx(k)));
        if (noisy && k >= 3 && k < 7)
          check(!in_ready, "R2 not ready while busy", 64'(in_ready), 64'd0);
      end
    end
    check(done && !busy, "R4 done after 16 rounds", {62'd0, done, busy}, 64'd2);
    res = out_block;
  endtask

  initial begin
    #(20ns * 150000);
    if (!ended) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] res, pt, ct, held;
    void'($urandom(32'd48611));
    load_kat_keys();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && in_ready && round_idx == 0 && out_block == 0, "R1 reset state",
          out_block, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && in_ready, "R1 idle after release", 64'(busy), 64'd0);

    // R5/R9: known answer
    dec_mode = 1'b0;
    run_block(KAT_PT, 1'b0, res);
    check(res == KAT_CT, "R5 R9 known answer", res, KAT_CT);
    @(negedge clk);
    check(!done, "R4 done one cycle", 64'(done), 64'd0);

    // R8: output held while idle
    repeat (10) @(negedge clk);
    check(out_block == KAT_CT && !done, "R8 hold while idle", out_block, KAT_CT);

    // R6: known-answer decryption
    dec_mode = 1'b1;
    run_block(KAT_CT, 1'b0, res);
    check(res == KAT_PT, "R6 known decrypt", res, KAT_PT);

    // R7: in_valid during flight is ignored
    dec_mode = 1'b0;
    run_block(KAT_PT, 1'b1, res);
    check(res == KAT_CT, "R7 result unchanged by mid-flight valid", res, KAT_CT);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (done || busy) check(1'b0, "R7 no extra block", 64'(done), 64'd0);
    end
    check(out_block == KAT_CT, "R7 R8 output intact", out_block, KAT_CT);

    // Overlap: second block waits on in_valid through the first block
    dec_mode = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_block = KAT_PT;
    @(negedge clk);
    in_block = KAT_CT;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k < 16) check(out_block == KAT_CT && !done, "R8 hold during next rounds", out_block, KAT_CT);
    end
    check(done && in_ready && out_block == KAT_CT, "R4 R2 done with waiting block", out_block, KAT_CT);
    dec_mode = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(busy && round_idx == 0 && !done, "R2 R3 waiting block taken", 64'(round_idx), 64'd0);
    held = out_block;
    check(held == KAT_CT, "R8 first result kept", held, KAT_CT);
    for (int k = 1; k <= 16; k++) @(negedge clk);
    check(done && out_block == KAT_PT, "R6 second result", out_block, KAT_PT);

    // R6: random round trips
    for (int t = 0; t < 24; t++) begin
      for (int i = 0; i < 16; i++) ks[i] = 48'({$urandom(), $urandom()});
      pt = {$urandom(), $urandom()};
      if (t == 0) pt = '0;
      if (t == 1) pt = '1;
      if (t == 2) for (int i = 0; i < 16; i++) ks[i] = '0;
      dec_mode = 1'b0;
      run_block(pt, 1'b0, ct);
      dec_mode = 1'b1;
      run_block(ct, t[0], res);
      check(res == pt, "R6 random round trip", res, pt);
    end

    ended = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule